// File: doc/BRIEF.md
# Shared-Address Baud/Frame Register Pair

This block is the register front end of a serial-port configuration unit. Two 8-bit registers sit behind a single I/O address. One holds the high part of the baud-rate divisor and the other holds the frame-control settings. The bit rate generator and the serial engine use the two register values directly, through dedicated outputs.

A write chooses its target from the most significant bit of the write data. When that bit is 1, the frame-control register takes the write. When it is 0, the baud-high register takes it. A read chooses its target by timing. A read with no read of the address in the cycle before it returns the baud-high register. A read that directly follows a baud-high read returns the frame-control register. Reads that keep coming on consecutive cycles alternate between the two registers. Any idle cycle or write cycle starts the sequence over at the baud-high register.

Read data is combinational and valid in the same cycle as the read strobe. Register outputs change on the clock edge that ends a write cycle.

Top module: `dualreg_top`

## Requirements
- R1: A write to the shared address with wrData[7] = 1 loads wrData[6:0] into frameCtl[6:0]. The same write leaves baudHi unchanged.
- R2: A write to the shared address with wrData[7] = 0 loads wrData[3:0] into baudHi[3:0]. The same write leaves frameCtl unchanged.
- R3: The baud-high register stores only 4 bits, so baudHi[7:4] and the matching read-back bits are always 0.
- R4: Bit 7 of the frame-control register is always 1, both on frameCtl and when it is read back.
- R5: A read cycle (rdStb = 1 and selHit = 1) that is not preceded by a read cycle returns baudHi on rdData in that same cycle.
- R6: A read cycle that directly follows a read cycle which returned baudHi returns frameCtl.
- R7: A read cycle that directly follows a read cycle which returned frameCtl returns baudHi. Unbroken runs of read cycles therefore alternate baudHi, frameCtl, baudHi, and so on.
- R8: Any cycle that is not a read cycle (idle, a write, or a read strobe without an address match) restarts the sequence, so the next read returns baudHi.
- R9: After reset, baudHi is 0x00 and frameCtl is 0x86, and the first read returns baudHi.
- R10: Strobes that arrive with selHit = 0 change neither register. rdData is 0x00 in any cycle that is not a read cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| selHit | input | 1 | The access targets the shared address |
| rdStb | input | 1 | One-cycle read strobe |
| wrStb | input | 1 | One-cycle write strobe |
| wrData | input | 8 | Write data; bit 7 selects the target register |
| rdData | output | 8 | Read data, valid in the read cycle |
| baudHi | output | 8 | Current baud-rate high register value |
| frameCtl | output | 8 | Current frame-control register value |

## Verification
The only hidden state is the one-bit record of whether the previous cycle was a baud-high read. An error in it shows at the ports on the very next read. The wrong register appears on rdData, and the two are easy to tell apart because bit 7 is 0 for baud-high and 1 for frame-control. An error in the write steering shows on baudHi or frameCtl one edge after the write, either as a missed update or as a change to the register that should have been left alone.

// File: rtl/dualreg_pkg.sv
package dualreg_pkg;
  // Strobes from the control to the datapath
  typedef struct packed {
    logic wrBaud;   // load the baud-high register
    logic wrFrame;  // load the frame-control register
    logic rdFrame;  // the current read selects frame-control
    logic rdOn;     // a read of the shared address is happening
  } regStrobe_t;
endpackage

// File: rtl/dualreg_ctrl.sv
module dualreg_ctrl
  import dualreg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       selHit,
  input  logic       rdStb,
  input  logic       wrStb,
  input  logic       selBit,
  output regStrobe_t strobe
);
  logic rdAct;
  logic wrAct;
  logic baudReadLast;  // the previous cycle was a read that returned baud-high

  assign rdAct = rdStb && selHit;
  assign wrAct = wrStb && selHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) baudReadLast <= 1'b0;
    else       baudReadLast <= rdAct && !baudReadLast;
  end

  always_comb begin
    strobe.rdOn    = rdAct;
    strobe.rdFrame = rdAct && baudReadLast;
    strobe.wrFrame = wrAct && selBit;
    strobe.wrBaud  = wrAct && !selBit;
  end
endmodule

// File: rtl/dualreg_dp.sv
module dualreg_dp
  import dualreg_pkg::*;
#(
  parameter int           DATA_W    = 8,
  parameter int           BAUD_W    = 4,
  parameter logic [7:0]   FRAME_RST = 8'h86
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic [DATA_W-2:0] wrLow,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] baudHi,
  output logic [DATA_W-1:0] frameCtl
);
  localparam int PAD_W = DATA_W - BAUD_W;

  logic [BAUD_W-1:0] baudQ;
  logic [DATA_W-2:0] frameQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              baudQ <= '0;
    else if (strobe.wrBaud) baudQ <= wrLow[BAUD_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               frameQ <= FRAME_RST[DATA_W-2:0];
    else if (strobe.wrFrame) frameQ <= wrLow;
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign baudHi = {{PAD_W{1'b0}}, baudQ};
    end else begin : g_full
      assign baudHi = baudQ[DATA_W-1:0];
    end
  endgenerate

  assign frameCtl = {1'b1, frameQ};

  always_comb begin
    if (!strobe.rdOn)        rdData = '0;
    else if (strobe.rdFrame) rdData = frameCtl;
    else                     rdData = baudHi;
  end
endmodule

// File: rtl/dualreg_top.sv
module dualreg_top
  import dualreg_pkg::*;
#(
  parameter int         DATA_W    = 8,
  parameter int         BAUD_W    = 4,
  parameter logic [7:0] FRAME_RST = 8'h86
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selHit,
  input  logic              rdStb,
  input  logic              wrStb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] baudHi,
  output logic [DATA_W-1:0] frameCtl
);
  regStrobe_t strobe;

  dualreg_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .selHit (selHit),
    .rdStb  (rdStb),
    .wrStb  (wrStb),
    .selBit (wrData[DATA_W-1]),
    .strobe (strobe)
  );

  dualreg_dp #(
    .DATA_W    (DATA_W),
    .BAUD_W    (BAUD_W),
    .FRAME_RST (FRAME_RST)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrLow    (wrData[DATA_W-2:0]),
    .rdData   (rdData),
    .baudHi   (baudHi),
    .frameCtl (frameCtl)
  );
endmodule

// File: rtl/dualreg_chk.sv
module dualreg_chk (
  input logic       clk,
  input logic       rstN,
  input logic       selHit,
  input logic       rdStb,
  input logic       wrStb,
  input logic [7:0] wrData,
  input logic [7:0] rdData,
  input logic [7:0] baudHi,
  input logic [7:0] frameCtl
);
  logic rdAct;
  logic wrAct;
  assign rdAct = rdStb && selHit;
  assign wrAct = wrStb && selHit;

  assert_frame_write_R1: assert property (@(posedge clk) disable iff (!rstN)
    (wrAct && wrData[7]) |=> (frameCtl[6:0] == $past(wrData[6:0])) && $stable(baudHi));

  assert_baud_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrAct && !wrData[7]) |=> (baudHi[3:0] == $past(wrData[3:0])) && $stable(frameCtl));

  assert_baud_pad_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rdAct && !$past(rdAct)) |-> (rdData[7:4] == 4'h0));

  assert_frame_top_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rdAct && $past(rdAct) && !$past(rdData[7])) |-> rdData[7]);

  assert_first_read_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rdAct && !$past(rdAct)) |-> (rdData == baudHi));

  assert_second_read_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rdAct && $past(rdAct) && !$past(rdData[7])) |-> (rdData == frameCtl));

  assert_third_read_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rdAct && $past(rdAct) && $past(rdData[7])) |-> (rdData == baudHi));

  assert_no_hit_R10: assert property (@(posedge clk) disable iff (!rstN)
    !wrAct |=> ($stable(baudHi) && $stable(frameCtl)));

  assert_idle_data_R10: assert property (@(posedge clk) disable iff (!rstN)
    !rdAct |-> (rdData == 8'h00));
endmodule

bind dualreg_top dualreg_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .selHit   (selHit),
  .rdStb    (rdStb),
  .wrStb    (wrStb),
  .wrData   (wrData),
  .rdData   (rdData),
  .baudHi   (baudHi),
  .frameCtl (frameCtl)
);

// File: tb/dualreg_top_tb.sv
module dualreg_top_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       selHit = 1'b0;
  logic       rdStb = 1'b0;
  logic       wrStb = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic [7:0] baudHi;
  logic [7:0] frameCtl;

  int  nRun = 0;
  int  nFail = 0;
  bit  done = 1'b0;

  always #5 clk = ~clk;

  dualreg_top u_dut (
    .clk(clk), .rstN(rstN), .selHit(selHit), .rdStb(rdStb), .wrStb(wrStb),
    .wrData(wrData), .rdData(rdData), .baudHi(baudHi), .frameCtl(frameCtl)
  );

  // {rd, wr, hit, 0} wrData expRd expBaud expFrame
  localparam int NV = 18;
  localparam logic [35:0] VEC [0:NV-1] = '{
    36'hA_00_00_00_86,  // R5 first read gives baud
    36'hA_00_86_00_86,  // R6 second gives frame
    36'hA_00_00_00_86,  // R7 third gives baud
    36'hA_00_86_00_86,  // R7 alternates
    36'h6_3B_00_0B_86,  // R3 / R2 upper baud bits dropped
    36'h6_C5_00_0B_C5,  // R1 frame write
    36'h6_80_00_0B_80,  // R4 frame bit 7 stays 1
    36'hA_00_0B_0B_80,  // R5
    36'h0_00_00_0B_80,  // R10 idle read data zero
    36'hA_00_0B_0B_80,  // R8 gap restarts
    36'hA_00_80_0B_80,  // R6
    36'h6_07_00_07_80,  // R2 baud write
    36'hA_00_07_07_80,  // R8 write broke sequence
    36'h8_00_00_07_80,  // R10 read strobe without hit
    36'hA_00_07_07_80,  // R8 unmatched strobe restarts
    36'h4_01_00_07_80,  // R10 write without hit ignored
    36'hA_00_07_07_80,  // R8
    36'hA_00_80_07_80   // R6
  };
  localparam int REQ [0:NV-1] = '{5,6,7,7,3,1,4,5,10,8,6,2,8,10,8,10,8,6};

  task automatic check(input int req, input string what, input logic [7:0] act, input logic [7:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic rd, input logic wr, input logic hit, input logic [7:0] d);
    @(negedge clk);
    rdStb = rd; wrStb = wr; selHit = hit; wrData = d;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    #1;
    check(9, "reset baudHi", baudHi, 8'h00);   // R9
    check(9, "reset frameCtl", frameCtl, 8'h86);
    check(10, "idle rdData", rdData, 8'h00);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][35], VEC[i][34], VEC[i][33], VEC[i][31:24]);
      #1;
      check(REQ[i], $sformatf("vec %0d rdData", i), rdData, VEC[i][23:16]);
      @(posedge clk); #1;
      check(REQ[i], $sformatf("vec %0d baudHi", i), baudHi, VEC[i][15:8]);
      check(REQ[i], $sformatf("vec %0d frameCtl", i), frameCtl, VEC[i][7:0]);
    end

    // R9: reset in the middle of a read run restarts at baud with defaults
    drive(1, 0, 1, 8'h00);
    @(negedge clk);
    rstN = 1'b0; rdStb = 1'b0; selHit = 1'b0;
    #1;
    check(9, "mid-run reset baudHi", baudHi, 8'h00);
    check(9, "mid-run reset frameCtl", frameCtl, 8'h86);
    @(negedge clk) rstN = 1'b1;
    drive(1, 0, 1, 8'h00);
    #1 check(9, "first read after reset", rdData, 8'h00);
    drive(1, 0, 1, 8'h00);
    #1 check(6, "second read after reset", rdData, 8'h86);

    // R7: a long run of back-to-back reads alternates
    drive(0, 1, 1, 8'h0A);
    for (int k = 0; k < 6; k++) begin
      drive(1, 0, 1, 8'h00);
      #1 check(7, $sformatf("run read %0d", k), rdData, (k % 2 == 0) ? 8'h0A : 8'h86);
    end
    drive(0, 0, 0, 8'h00);
    @(negedge clk);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule